// File: doc/BRIEF.md
# Root Hub Downstream Port Status Register

This block holds the status and control word of a single downstream port of a USB host controller root hub. It records whether a device is present, whether the port is enabled, suspended, in bus reset or powered, whether the attached device is low speed, and whether an over-current condition is sensed. For each of connect, enable, suspend, over-current and reset it also keeps a sticky change flag. Software reaches the port through a 32-bit register write port and a read port. The port logic supplies attach and detach events, the speed of the newly attached device and an over-current level.

A write uses one-to-set and one-to-clear semantics, and a zero bit in a write changes nothing. Requests to enable, suspend or reset the port take effect only while a device is present. With no device present, such a request sets the connect-change flag instead. A port reset drives a one-cycle bus reset pulse toward the device. It then holds the reset bit for a parameterised number of cycles and completes by enabling the port. Every change of the visible word produces a one-cycle status-change pulse for the interrupt logic.

The asynchronous active-low reset is released through a two-stage synchroniser inside the block. All state is zero after reset.

Top module: `hub_port_reg`

## Requirements
- R1: After reset the read word is zero, and both `chg_pulse_o` and `bus_reset_o` are low.
- R2: The read word has connect at bit 0, enable 1, suspend 2, over-current 3, reset 4, power 8 and low-speed 9. The change flags sit at bits 16 (connect), 17 (enable), 18 (suspend), 19 (over-current) and 20 (reset). Writing 1 to bits 16 to 20 clears the matching flag. A write whose bits are all zero changes nothing.
- R3: Writing 1 to bit 0 clears the enable bit.
- R4: Writing 1 to bit 1, 2 or 4 sets that bit only while connect is 1. While connect is 0, the write sets connect-change (bit 16) instead.
- R5: When the reset bit is newly set, or is set again in the cycle a reset completes, `bus_reset_o` is high for exactly one cycle, in the cycle the bit first reads as 1. The reset bit then reads 1 for RST_CYCLES cycles. It then clears while enable (bit 1) and reset-change (bit 20) are set.
- R6: Writing 1 to bit 9 removes power (bit 8) and clears enable, suspend and reset. Writing 1 to bit 8 applies power. A write with both bits set leaves power on.
- R7: An attach sets connect and connect-change if connect was 0. Each attach also loads low-speed (bit 9) from `dev_lowspeed_i`. When attach and detach arrive in the same cycle, the detach is ignored.
- R8: A detach on a connected port clears connect and sets connect-change. If the port was enabled, the detach also clears enable and sets enable-change (bit 17).
- R9: Bit 3 reads as `ovc_i` sampled one clock earlier. Every change of that sampled value sets over-current-change (bit 19).
- R10: `chg_pulse_o` is high in exactly those cycles where the read word differs from its value in the previous cycle.
- R11: Within one cycle, reset completion is applied first, then the register write, then attach, detach and over-current sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attach_i | input | 1 | Device attached (one-cycle event) |
| detach_i | input | 1 | Device detached (one-cycle event) |
| dev_lowspeed_i | input | 1 | Speed of the device being attached, 1 = low speed |
| ovc_i | input | 1 | Over-current sense level |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register value |
| chg_pulse_o | output | 1 | Status-change event for the interrupt logic |
| bus_reset_o | output | 1 | One-cycle request for a bus reset of the device |

## Verification
The bench targets enable, suspend and reset requests on an empty port. A design that ignored the connect condition would enable a port with no device behind it and would never raise connect-change. It writes power-on and power-off together; a design with the wrong order would leave the port unpowered. It drives detach in the same cycle as an enable write, and attach together with detach. Wrong ordering there shows up as a stale enable bit, a missing enable-change flag or a lost connect. It counts the cycles of the reset bit exactly and re-arms reset in the cycle it completes. An off-by-one timer, or a bus reset pulse that is lost or doubled, then becomes visible.

// File: rtl/hub_port_pkg.sv
package hub_port_pkg;

  localparam int W_REG      = 32;
  localparam int B_CONN     = 0;
  localparam int B_EN       = 1;
  localparam int B_SUSP     = 2;
  localparam int B_OVC      = 3;
  localparam int B_RST      = 4;
  localparam int B_PWR      = 8;
  localparam int B_LS       = 9;
  localparam int B_CONN_CHG = 16;
  localparam int B_EN_CHG   = 17;
  localparam int B_SUSP_CHG = 18;
  localparam int B_OVC_CHG  = 19;
  localparam int B_RST_CHG  = 20;

  typedef struct packed {
    logic conn;
    logic en;
    logic susp;
    logic ovc;
    logic rst;
    logic pwr;
    logic ls;
    logic conn_chg;
    logic en_chg;
    logic susp_chg;
    logic ovc_chg;
    logic rst_chg;
  } port_st_t;

  function automatic logic [W_REG-1:0] st_pack(port_st_t s);
    logic [W_REG-1:0] w;
    w             = '0;
    w[B_CONN]     = s.conn;
    w[B_EN]       = s.en;
    w[B_SUSP]     = s.susp;
    w[B_OVC]      = s.ovc;
    w[B_RST]      = s.rst;
    w[B_PWR]      = s.pwr;
    w[B_LS]       = s.ls;
    w[B_CONN_CHG] = s.conn_chg;
    w[B_EN_CHG]   = s.en_chg;
    w[B_SUSP_CHG] = s.susp_chg;
    w[B_OVC_CHG]  = s.ovc_chg;
    w[B_RST_CHG]  = s.rst_chg;
    return w;
  endfunction

endpackage

// File: rtl/hub_port_rst_timer.sv
module hub_port_rst_timer #(
  parameter int RST_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = active && (cnt_q == LAST);

  // count while the reset bit is held; restart at completion
  always_comb begin
    if (active && !done) cnt_d = cnt_q + CW'(1);
    else                 cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: the timer advances by one each cycle of a running reset
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/hub_port_next.sv
module hub_port_next
  import hub_port_pkg::*;
(
  input  port_st_t         cur,
  input  logic             rst_done,
  input  logic             wr_en,
  input  logic [W_REG-1:0] wr_data,
  input  logic             attach,
  input  logic             detach,
  input  logic             dev_ls,
  input  logic             ovc_in,
  output port_st_t         nxt,
  output logic             rst_arm
);
  logic connected;
  logic unused_wr_bits;

  assign connected      = cur.conn;
  assign unused_wr_bits = ^{wr_data[W_REG-1:B_RST_CHG+1], wr_data[B_PWR-1:B_RST+1],
                            wr_data[B_CONN_CHG-1:B_LS+1], wr_data[B_OVC]};

  always_comb begin
    nxt = cur;
    // stage 1: reset completion
    if (rst_done) begin
      nxt.rst     = 1'b0;
      nxt.en      = 1'b1;
      nxt.rst_chg = 1'b1;
    end
    // stage 2: register write
    if (wr_en) begin
      if (wr_data[B_CONN_CHG]) nxt.conn_chg = 1'b0;
      if (wr_data[B_EN_CHG])   nxt.en_chg   = 1'b0;
      if (wr_data[B_SUSP_CHG]) nxt.susp_chg = 1'b0;
      if (wr_data[B_OVC_CHG])  nxt.ovc_chg  = 1'b0;
      if (wr_data[B_RST_CHG])  nxt.rst_chg  = 1'b0;
      if (wr_data[B_CONN])     nxt.en       = 1'b0;
      if (wr_data[B_EN]) begin
        if (connected) nxt.en = 1'b1;
        else           nxt.conn_chg = 1'b1;
      end
      if (wr_data[B_SUSP]) begin
        if (connected) nxt.susp = 1'b1;
        else           nxt.conn_chg = 1'b1;
      end
      if (wr_data[B_RST]) begin
        if (connected) nxt.rst = 1'b1;
        else           nxt.conn_chg = 1'b1;
      end
      // power removal first so a combined request ends powered
      if (wr_data[B_LS]) begin
        nxt.pwr  = 1'b0;
        nxt.en   = 1'b0;
        nxt.susp = 1'b0;
        nxt.rst  = 1'b0;
      end
      if (wr_data[B_PWR]) nxt.pwr = 1'b1;
    end
    // stage 3: port events
    if (attach) begin
      if (!nxt.conn) begin
        nxt.conn     = 1'b1;
        nxt.conn_chg = 1'b1;
      end
      nxt.ls = dev_ls;
    end else if (detach) begin
      if (nxt.conn) begin
        nxt.conn     = 1'b0;
        nxt.conn_chg = 1'b1;
      end
      if (nxt.en) begin
        nxt.en     = 1'b0;
        nxt.en_chg = 1'b1;
      end
    end
    if (ovc_in != cur.ovc) begin
      nxt.ovc     = ovc_in;
      nxt.ovc_chg = 1'b1;
    end
  end

  assign rst_arm = nxt.rst && (!cur.rst || rst_done);

endmodule

// File: rtl/hub_port_reg.sv
module hub_port_reg
  import hub_port_pkg::*;
#(
  parameter int RST_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        attach_i,
  input  logic        detach_i,
  input  logic        dev_lowspeed_i,
  input  logic        ovc_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        chg_pulse_o,
  output logic        bus_reset_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  port_st_t   st_q, st_d;
  logic       rst_done, rst_arm;
  logic       chg_q, brst_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  hub_port_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .active (st_q.rst),
    .done   (rst_done)
  );

  hub_port_next u_next (
    .cur      (st_q),
    .rst_done (rst_done),
    .wr_en    (wr_en_i),
    .wr_data  (wr_data_i),
    .attach   (attach_i),
    .detach   (detach_i),
    .dev_ls   (dev_lowspeed_i),
    .ovc_in   (ovc_i),
    .nxt      (st_d),
    .rst_arm  (rst_arm)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= '0;
      chg_q  <= 1'b0;
      brst_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      chg_q  <= (st_d != st_q);
      brst_q <= rst_arm;
    end
  end

  assign rd_data_o   = st_pack(st_q);
  assign chg_pulse_o = chg_q;
  assign bus_reset_o = brst_q;

  // R10: change event marks exactly the cycles where the word moved
  p_chg_match_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chg_pulse_o == (rd_data_o != $past(rd_data_o)));

  // R5: the bus reset request lasts a single cycle
  p_brst_single_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_reset_o |=> !bus_reset_o);

  // R4: suspend cannot appear on a port with no device
  p_susp_needs_conn_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_data_o[B_CONN] && !rd_data_o[B_SUSP] && !attach_i) |=> !rd_data_o[B_SUSP]);

  // R6: a lone power-off request leaves the port unpowered
  p_pwr_off_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && wr_data_i[B_LS] && !wr_data_i[B_PWR]) |=> !rd_data_o[B_PWR]);

  // R9: over-current bit follows the sense input one cycle late
  p_ovc_follow_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (rd_data_o[B_OVC] == $past(ovc_i)));

endmodule

// File: tb/hub_port_reg_bench.sv
module hub_port_reg_bench;
  localparam int RST_C = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        attach_i, detach_i, dev_lowspeed_i, ovc_i, wr_en_i;
  logic [31:0] wr_data_i;
  logic [31:0] rd_data_o;
  logic        chg_pulse_o, bus_reset_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] m_reg;
  int          m_cnt;
  logic        m_chg, m_brst;
  bit          finished = 0;

  always #4 clk = ~clk;

  hub_port_reg #(.RST_CYCLES(RST_C)) u_hub_port_reg (
    .clk(clk), .rst_n(rst_n), .attach_i(attach_i), .detach_i(detach_i),
    .dev_lowspeed_i(dev_lowspeed_i), .ovc_i(ovc_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .chg_pulse_o(chg_pulse_o),
    .bus_reset_o(bus_reset_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected next word from the requirements (R2..R9, order per R11)
  function automatic logic [31:0] model_next(input logic [31:0] s0, input bit done,
      input logic wr, input logic [31:0] w, input logic at, input logic dt,
      input logic ls, input logic oc);
    logic [31:0] s;
    s = s0;
    if (done) begin s[4] = 0; s[1] = 1; s[20] = 1; end
    if (wr) begin
      for (int b = 16; b <= 20; b++) if (w[b]) s[b] = 0;
      if (w[0]) s[1] = 0;
      if (w[1]) begin if (s0[0]) s[1] = 1; else s[16] = 1; end
      if (w[2]) begin if (s0[0]) s[2] = 1; else s[16] = 1; end
      if (w[4]) begin if (s0[0]) s[4] = 1; else s[16] = 1; end
      if (w[9]) begin s[8] = 0; s[1] = 0; s[2] = 0; s[4] = 0; end
      if (w[8]) s[8] = 1;
    end
    if (at) begin
      if (!s[0]) begin s[0] = 1; s[16] = 1; end
      s[9] = ls;
    end else if (dt) begin
      if (s[0]) begin s[0] = 0; s[16] = 1; end
      if (s[1]) begin s[1] = 0; s[17] = 1; end
    end
    if (oc != s0[3]) begin s[3] = oc; s[19] = 1; end
    return s;
  endfunction

  // called at a falling edge; drives one cycle and compares at the next falling edge
  task automatic step(input logic wr, input logic [31:0] w, input logic at,
      input logic dt, input logic ls, input logic oc, input string tag);
    logic [31:0] nx;
    bit done;
    wr_en_i = wr; wr_data_i = w; attach_i = at; detach_i = dt;
    dev_lowspeed_i = ls; ovc_i = oc;
    done   = m_reg[4] && (m_cnt == RST_C - 1);
    nx     = model_next(m_reg, done, wr, w, at, dt, ls, oc);
    m_brst = nx[4] && (!m_reg[4] || done);
    m_chg  = (nx != m_reg);
    m_cnt  = (m_reg[4] && !done) ? m_cnt + 1 : 0;
    m_reg  = nx;
    @(negedge clk);
    chk({tag, " word"},  rd_data_o, m_reg);
    chk("R10 chg",       {31'd0, chg_pulse_o}, {31'd0, m_chg});
    chk("R5 busreset",   {31'd0, bus_reset_o}, {31'd0, m_brst});
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'd0, 1'b0, 1'b0, dev_lowspeed_i, ovc_i, tag);
  endtask

  task automatic wr(input logic [31:0] w, input string tag);
    step(1'b1, w, 1'b0, 1'b0, 1'b0, ovc_i, tag);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst_n = 1'b0; attach_i = 0; detach_i = 0; dev_lowspeed_i = 0;
    ovc_i = 0; wr_en_i = 0; wr_data_i = '0;
    m_reg = '0; m_cnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 word", rd_data_o, 32'd0);
    chk("R1 chg",  {31'd0, chg_pulse_o}, 32'd0);
    chk("R1 brst", {31'd0, bus_reset_o}, 32'd0);

    // R4 enable request with nothing attached
    wr(32'h0000_0002, "R4");
    chk("R4 enable blocked", rd_data_o, 32'h0001_0000);
    // R2 zero write leaves the word, one-to-clear removes the flag
    wr(32'h0000_0000, "R2");
    chk("R2 zero write", rd_data_o, 32'h0001_0000);
    wr(32'h0001_0000, "R2");
    chk("R2 clear flag", rd_data_o, 32'h0000_0000);

    // R7 attach of a low-speed device
    step(1'b0, 32'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    chk("R7 attach", rd_data_o, 32'h0001_0201);
    wr(32'h0001_0000, "R2");

    // R6 both power bits: power stays on
    wr(32'h0000_0300, "R6");
    chk("R6 both power", rd_data_o & 32'h0000_0100, 32'h0000_0100);

    // R5 reset sequence
    wr(32'h0000_0010, "R5");
    chk("R5 reset set", {31'd0, rd_data_o[4]}, 32'd1);
    chk("R5 pulse", {31'd0, bus_reset_o}, 32'd1);
    for (int i = 1; i < RST_C; i++) begin
      idle("R5");
      chk("R5 reset held", {31'd0, rd_data_o[4]}, 32'd1);
    end
    idle("R5");
    chk("R5 complete", rd_data_o & 32'h0010_0012, 32'h0010_0002);

    // R3 connect-position write disables the port
    wr(32'h0000_0001, "R3");
    chk("R3 disable", {31'd0, rd_data_o[1]}, 32'd0);

    // R5 re-arm in the completion cycle
    wr(32'h0010_0010, "R5");
    for (int i = 1; i < RST_C; i++) idle("R5");
    step(1'b1, 32'h0000_0010, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    chk("R5 rearm pulse", {31'd0, bus_reset_o}, 32'd1);
    chk("R5 rearm held",  {31'd0, rd_data_o[4]}, 32'd1);
    for (int i = 1; i < RST_C; i++) idle("R5");
    idle("R5");

    // R11 enable write and detach together: detach wins
    wr(32'h001F_0000, "R2");
    step(1'b1, 32'h0000_0002, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
    chk("R11 write then detach", rd_data_o & 32'h0003_0003, 32'h0003_0000);

    // R8 detach of an enabled port
    wr(32'h001F_0000, "R2");
    step(1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    wr(32'h0000_0002, "R8");
    step(1'b0, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    chk("R8 detach", rd_data_o & 32'h0003_0003, 32'h0003_0000);

    // R7 attach and detach in one cycle: attach wins
    step(1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    chk("R7 attach beats detach", {31'd0, rd_data_o[0]}, 32'd1);

    // R6 power-off clears enable and suspend
    wr(32'h0000_0106, "R6");
    wr(32'h0000_0200, "R6");
    chk("R6 power off", rd_data_o & 32'h0000_0116, 32'h0000_0000);

    // R9 over-current sense
    step(1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    chk("R9 ovc", rd_data_o & 32'h0008_0008, 32'h0008_0008);
    idle("R10");
    chk("R10 quiet", {31'd0, chg_pulse_o}, 32'd0);

    // constrained random mix, ordering per R11
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      logic oc;
      w  = $urandom & 32'h001F_031F;
      if ($urandom_range(0, 3) != 0) w = w & ~32'h0000_0200;
      oc = ($urandom_range(0, 31) == 0) ? ~ovc_i : ovc_i;
      step($urandom_range(0, 2) == 0, w, $urandom_range(0, 15) == 0,
           $urandom_range(0, 15) == 0, 1'($urandom), oc, "R11");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule